// File: doc/BRIEF.md
# Bus Master Security Filter

The filter sits between one bus master and a downstream memory port. Every read or write the master issues is classified into one of four outcomes: forwarded with the secure attribute set, forwarded with the secure attribute clear, dropped silently (reads return zero, writes vanish, the response is good), or dropped with an error response. The request address is presented to an external attribution lookup. The lookup answers in the same cycle with two flags: "exempt from checking" and "non-secure region".

Three static control inputs are registered inside the block, so each one takes effect on the cycle after it is presented. The first says whether the master is non-secure. The second selects whether a blocked access gets an error or the silent read-as-zero treatment. The third is an interrupt-clear level. Every error-blocked access latches a level interrupt. A high clear level removes the interrupt and, while it is held, stops new ones from being latched.

The master side uses a valid/ready request channel and a response channel with no backpressure. The filter has at most one access in flight. A blocked access is answered locally one cycle after acceptance and never reaches the downstream port. An allowed access is replayed downstream unchanged, and the downstream response is returned as it came.

Top module: `bus_sec_filter`

## Requirements
- R1: When the lookup reports the address exempt, the access is forwarded. `dn_req_secure` is 0 if the registered master-non-secure control is 1, and 1 otherwise. The non-secure flag is then ignored.
- R2: A non-exempt address that the lookup reports as non-secure is forwarded with `dn_req_secure` = 0, whatever the master configuration.
- R3: A non-exempt, secure-attributed address accessed while the master is configured secure is forwarded with `dn_req_secure` = 1.
- R4: A non-exempt, secure-attributed address accessed by a master configured non-secure, with the error-on-block control at 0, is answered locally with `up_rsp_rdata` = 0 and `up_rsp_err` = 0. No downstream request is made, so a write is dropped.
- R5: The same blocked access with the error-on-block control at 1 is answered locally with `up_rsp_err` = 1 and `up_rsp_rdata` = 0, and no downstream request is made.
- R6: An error-blocked access accepted while the registered interrupt-clear level is 0 makes `irq_o` 1 from the next cycle on. `irq_o` then stays 1 until the clear level is seen. An error-blocked access accepted while the clear level is 1 does not raise `irq_o`.
- R7: A registered interrupt-clear level of 1 forces `irq_o` to 0 on the next cycle. Clearing takes priority over a simultaneous setting.
- R8: Reset clears the interrupt and all three registered controls. After reset, `up_req_ready` = 1, while `dn_req_valid`, `up_rsp_valid` and `irq_o` are 0.
- R9: A forwarded request carries the master's address, write flag, size code (0 = 1 byte, 1 = 2, 2 = 4, 3 = 8 bytes, little-endian lanes) and write data unchanged. These fields are held while `dn_req_ready` is low. The downstream read data and error flag are returned to the master unchanged.
- R10: A blocked access is answered in the cycle right after its acceptance. While an allowed access is in flight, `up_req_ready` is 0. The downstream port must respond no earlier than the cycle after its request handshake.
- R11: The three control inputs are registered: the controls applied to an access are the input levels from the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_nsec_master | input | 1 | Master is non-secure (registered) |
| cfg_err_on_block | input | 1 | Blocked accesses get an error instead of read-as-zero (registered) |
| irq_clr | input | 1 | Interrupt-clear level (registered) |
| irq_o | output | 1 | Level interrupt for error-blocked accesses |
| attr_addr | output | ADDR_W | Address presented to the attribution lookup |
| attr_exempt | input | 1 | Lookup: address exempt from checking |
| attr_nsec | input | 1 | Lookup: address is non-secure |
| up_req_valid | input | 1 | Master request valid |
| up_req_ready | output | 1 | Filter can accept a request |
| up_req_addr | input | ADDR_W | Request address |
| up_req_write | input | 1 | 1 = write, 0 = read |
| up_req_size | input | 2 | Size code, 2^size bytes |
| up_req_wdata | input | DATA_W | Write data |
| up_rsp_valid | output | 1 | Response valid for one cycle |
| up_rsp_rdata | output | DATA_W | Read data |
| up_rsp_err | output | 1 | Error response |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream accepts request |
| dn_req_addr | output | ADDR_W | Downstream address |
| dn_req_write | output | 1 | Downstream write flag |
| dn_req_size | output | 2 | Downstream size code |
| dn_req_wdata | output | DATA_W | Downstream write data |
| dn_req_secure | output | 1 | Security attribute, 1 = secure |
| dn_rsp_valid | input | 1 | Downstream response valid |
| dn_rsp_rdata | input | DATA_W | Downstream read data |
| dn_rsp_err | input | 1 | Downstream error flag |

## Verification
With a secure master, the bench mixes secure-region, non-secure-region and exempt addresses. This shows that exempt and non-secure attribution resolve differently from plain secure attribution. The same address kinds are then run with a non-secure master, once with silent blocking and once with error blocking, to separate the read-as-zero path from the error path, and the exempt path from the non-secure-region path. The interrupt is exercised with the clear level low, held high across a blocked access, and raised at the same time as a block. The bench also covers back-to-back blocked accesses, downstream errors and stalls, and a reset while the interrupt is set. Each case shows whether suppression, priority and the local response timing behave as intended.

// File: rtl/sec_filter_pkg.sv
`timescale 1ns/1ps
package sec_filter_pkg;

    // Per-access outcome
    typedef enum logic [1:0] {
        ACT_PASS_SEC  = 2'd0,
        ACT_PASS_NSEC = 2'd1,
        ACT_DROP_ZERO = 2'd2,
        ACT_DROP_ERR  = 2'd3
    } sf_act_e;

    // Transaction engine state
    typedef enum logic [1:0] {
        XS_IDLE  = 2'd0,
        XS_ISSUE = 2'd1,
        XS_WAIT  = 2'd2
    } sf_xs_e;

    // Registered control levels
    typedef struct packed {
        logic master_nsec;
        logic err_on_block;
        logic irq_clr;
    } sf_ctrl_t;

    localparam int SIZE_W = 2;

    function automatic logic act_blocked(input sf_act_e a);
        return (a == ACT_DROP_ZERO) || (a == ACT_DROP_ERR);
    endfunction

endpackage

// File: rtl/sf_decide.sv
`timescale 1ns/1ps
module sf_decide
    import sec_filter_pkg::*;
(
    input  logic    master_nsec_i,
    input  logic    err_on_block_i,
    input  logic    exempt_i,
    input  logic    nsec_i,
    output sf_act_e act_o
);

    // Priority: exemption, then non-secure region, then master security.
    always_comb begin
        if (exempt_i) begin
            act_o = master_nsec_i ? ACT_PASS_NSEC : ACT_PASS_SEC;
        end else if (nsec_i) begin
            act_o = ACT_PASS_NSEC;
        end else if (!master_nsec_i) begin
            act_o = ACT_PASS_SEC;
        end else if (err_on_block_i) begin
            act_o = ACT_DROP_ERR;
        end else begin
            act_o = ACT_DROP_ZERO;
        end
    end

endmodule

// File: rtl/sf_irq_latch.sv
`timescale 1ns/1ps
module sf_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_o
);

    logic irq_d, irq_q;

    always_comb begin
        irq_d = irq_q;
        if (set_i) irq_d = 1'b1;
        if (clr_i) irq_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq_o = irq_q;

    assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !irq_o);
    assert_set_latches_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_i) |=> irq_o);
    assert_level_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !clr_i) |=> irq_o);
    assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && !set_i) |=> !irq_o);

endmodule

// File: rtl/sf_xact.sv
`timescale 1ns/1ps
module sf_xact
    import sec_filter_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sf_act_e           act_i,
    output logic              acc_o,
    input  logic              up_req_valid,
    output logic              up_req_ready,
    input  logic [ADDR_W-1:0] up_req_addr,
    input  logic              up_req_write,
    input  logic [SIZE_W-1:0] up_req_size,
    input  logic [DATA_W-1:0] up_req_wdata,
    output logic              up_rsp_valid,
    output logic [DATA_W-1:0] up_rsp_rdata,
    output logic              up_rsp_err,
    output logic              dn_req_valid,
    input  logic              dn_req_ready,
    output logic [ADDR_W-1:0] dn_req_addr,
    output logic              dn_req_write,
    output logic [SIZE_W-1:0] dn_req_size,
    output logic [DATA_W-1:0] dn_req_wdata,
    output logic              dn_req_secure,
    input  logic              dn_rsp_valid,
    input  logic [DATA_W-1:0] dn_rsp_rdata,
    input  logic              dn_rsp_err
);

    typedef struct packed {
        sf_xs_e            st;
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic [SIZE_W-1:0] size;
        logic [DATA_W-1:0] wdata;
        logic              sec;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
        logic              rerr;
    } xact_t;

    xact_t x_d, x_q;
    logic  acc;

    assign up_req_ready = (x_q.st == XS_IDLE);
    assign acc          = up_req_valid && up_req_ready;
    assign acc_o        = acc;

    always_comb begin
        x_d        = x_q;
        x_d.rvalid = 1'b0;
        unique case (x_q.st)
            XS_IDLE: begin
                if (acc) begin
                    unique case (act_i)
                        ACT_DROP_ZERO: begin
                            x_d.rvalid = 1'b1;
                            x_d.rdata  = '0;
                            x_d.rerr   = 1'b0;
                        end
                        ACT_DROP_ERR: begin
                            x_d.rvalid = 1'b1;
                            x_d.rdata  = '0;
                            x_d.rerr   = 1'b1;
                        end
                        default: begin
                            x_d.st    = XS_ISSUE;
                            x_d.addr  = up_req_addr;
                            x_d.wr    = up_req_write;
                            x_d.size  = up_req_size;
                            x_d.wdata = up_req_wdata;
                            x_d.sec   = (act_i == ACT_PASS_SEC);
                        end
                    endcase
                end
            end
            XS_ISSUE: begin
                if (dn_req_ready) x_d.st = XS_WAIT;
            end
            XS_WAIT: begin
                if (dn_rsp_valid) begin
                    x_d.rvalid = 1'b1;
                    x_d.rdata  = dn_rsp_rdata;
                    x_d.rerr   = dn_rsp_err;
                    x_d.st     = XS_IDLE;
                end
            end
            default: x_d.st = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) x_q <= '0;
        else        x_q <= x_d;
    end

    assign up_rsp_valid  = x_q.rvalid;
    assign up_rsp_rdata  = x_q.rdata;
    assign up_rsp_err    = x_q.rerr;
    assign dn_req_valid  = (x_q.st == XS_ISSUE);
    assign dn_req_addr   = x_q.addr;
    assign dn_req_write  = x_q.wr;
    assign dn_req_size   = x_q.size;
    assign dn_req_wdata  = x_q.wdata;
    assign dn_req_secure = x_q.sec;

    assert_zero_reply_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && act_i == ACT_DROP_ZERO) |=> (up_rsp_valid && up_rsp_rdata == '0 && !up_rsp_err));
    assert_err_reply_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && act_i == ACT_DROP_ERR) |=> (up_rsp_valid && up_rsp_err));
    assert_block_local_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && act_blocked(act_i)) |=> (!dn_req_valid && up_req_ready));
    assert_sec_attr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && act_i == ACT_PASS_SEC) |=> (dn_req_valid && dn_req_secure));
    assert_nsec_attr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && act_i == ACT_PASS_NSEC) |=> (dn_req_valid && !dn_req_secure));
    assert_fields_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req_valid && !dn_req_ready) |=> (dn_req_valid && $stable(dn_req_addr)
            && $stable(dn_req_wdata) && $stable(dn_req_secure) && $stable(dn_req_size)));
    assert_single_flight_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req_valid |-> !up_req_ready);

endmodule

// File: rtl/bus_sec_filter.sv
`timescale 1ns/1ps
module bus_sec_filter
    import sec_filter_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_nsec_master,
    input  logic              cfg_err_on_block,
    input  logic              irq_clr,
    output logic              irq_o,
    output logic [ADDR_W-1:0] attr_addr,
    input  logic              attr_exempt,
    input  logic              attr_nsec,
    input  logic              up_req_valid,
    output logic              up_req_ready,
    input  logic [ADDR_W-1:0] up_req_addr,
    input  logic              up_req_write,
    input  logic [1:0]        up_req_size,
    input  logic [DATA_W-1:0] up_req_wdata,
    output logic              up_rsp_valid,
    output logic [DATA_W-1:0] up_rsp_rdata,
    output logic              up_rsp_err,
    output logic              dn_req_valid,
    input  logic              dn_req_ready,
    output logic [ADDR_W-1:0] dn_req_addr,
    output logic              dn_req_write,
    output logic [1:0]        dn_req_size,
    output logic [DATA_W-1:0] dn_req_wdata,
    output logic              dn_req_secure,
    input  logic              dn_rsp_valid,
    input  logic [DATA_W-1:0] dn_rsp_rdata,
    input  logic              dn_rsp_err
);

    sf_ctrl_t ctrl_d, ctrl_q;
    sf_act_e  act;
    logic     acc;
    logic     irq_set;

    // R11: control levels are registered before use
    always_comb begin
        ctrl_d.master_nsec  = cfg_nsec_master;
        ctrl_d.err_on_block = cfg_err_on_block;
        ctrl_d.irq_clr      = irq_clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign attr_addr = up_req_addr;

    sf_decide u_decide (
        .master_nsec_i  (ctrl_q.master_nsec),
        .err_on_block_i (ctrl_q.err_on_block),
        .exempt_i       (attr_exempt),
        .nsec_i         (attr_nsec),
        .act_o          (act)
    );

    sf_xact #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_xact (
        .clk           (clk),
        .rst_n         (rst_n),
        .act_i         (act),
        .acc_o         (acc),
        .up_req_valid  (up_req_valid),
        .up_req_ready  (up_req_ready),
        .up_req_addr   (up_req_addr),
        .up_req_write  (up_req_write),
        .up_req_size   (up_req_size),
        .up_req_wdata  (up_req_wdata),
        .up_rsp_valid  (up_rsp_valid),
        .up_rsp_rdata  (up_rsp_rdata),
        .up_rsp_err    (up_rsp_err),
        .dn_req_valid  (dn_req_valid),
        .dn_req_ready  (dn_req_ready),
        .dn_req_addr   (dn_req_addr),
        .dn_req_write  (dn_req_write),
        .dn_req_size   (dn_req_size),
        .dn_req_wdata  (dn_req_wdata),
        .dn_req_secure (dn_req_secure),
        .dn_rsp_valid  (dn_rsp_valid),
        .dn_rsp_rdata  (dn_rsp_rdata),
        .dn_rsp_err    (dn_rsp_err)
    );

    // R6: a held clear level suppresses new latching
    assign irq_set = acc && (act == ACT_DROP_ERR) && !ctrl_q.irq_clr;

    sf_irq_latch u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (irq_set),
        .clr_i (ctrl_q.irq_clr),
        .irq_o (irq_o)
    );

    assert_exempt_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (up_req_valid && up_req_ready && attr_exempt) |=> (dn_req_valid && dn_req_secure == !$past(ctrl_q.master_nsec)));
    assert_irq_needs_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && !(up_req_valid && up_req_ready)) |=> !irq_o);

endmodule

// File: tb/bus_sec_filter_tb_top.sv
`timescale 1ns/1ps
module bus_sec_filter_tb_top;

    localparam int AW = 32;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_nsec_master = 1'b0, cfg_err_on_block = 1'b0, irq_clr = 1'b0;
    logic          irq_o;
    logic [AW-1:0] attr_addr;
    logic          attr_exempt, attr_nsec;
    logic          up_req_valid = 1'b0, up_req_ready;
    logic [AW-1:0] up_req_addr = '0;
    logic          up_req_write = 1'b0;
    logic [1:0]    up_req_size = '0;
    logic [DW-1:0] up_req_wdata = '0;
    logic          up_rsp_valid, up_rsp_err;
    logic [DW-1:0] up_rsp_rdata;
    logic          dn_req_valid, dn_req_ready = 1'b0;
    logic [AW-1:0] dn_req_addr;
    logic          dn_req_write, dn_req_secure;
    logic [1:0]    dn_req_size;
    logic [DW-1:0] dn_req_wdata;
    logic          dn_rsp_valid = 1'b0, dn_rsp_err = 1'b0;
    logic [DW-1:0] dn_rsp_rdata = '0;

    always #2.5 clk = ~clk;

    // Attribution lookup: 0xF0xxxxxx exempt, bit 31 set means non-secure
    assign attr_exempt = (attr_addr[31:24] == 8'hF0);
    assign attr_nsec   = attr_addr[31];

    bus_sec_filter #(.ADDR_W(AW), .DATA_W(DW)) dut_i (.*);

    typedef struct {
        int            cyc;
        logic [DW-1:0] data;
        logic          err;
        int            tag;
    } exp_t;
    typedef struct {
        logic [AW-1:0] addr;
        logic          wr;
        logic [1:0]    size;
        logic [DW-1:0] wdata;
        logic          sec;
        int            tag;
    } dn_t;

    exp_t expq[$];
    dn_t  dnq[$];
    int   checks = 0, errors = 0, cyc = 0;
    int   hs_count = 0;
    logic [AW-1:0] hs_addr = '0;
    logic ref_ns = 0, ref_er = 0, ref_clr = 0, ref_irq = 0;
    bit   timeout = 0;

    function automatic string tagname(input int t);
        case (t)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            8: return "R8";
            9: return "R9";
            10: return "R10";
            default: return "R11";
        endcase
    endfunction

    // outcome code: 0 pass secure, 1 pass non-secure, 2 zero-block, 3 error-block
    function automatic int model_act(input logic [AW-1:0] a, input logic ns, input logic er);
        if (a[31:24] == 8'hF0) return ns ? 1 : 0;
        if (a[31])             return 1;
        if (!ns)               return 0;
        return er ? 3 : 2;
    endfunction

    function automatic int model_tag(input logic [AW-1:0] a, input logic ns, input logic er);
        if (a[31:24] == 8'hF0) return 1;
        if (a[31])             return 2;
        if (!ns)               return 3;
        return er ? 5 : 4;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // Reference model and comparison, evaluated mid-cycle
    always @(negedge clk) begin
        if (!rst_n) begin
            ref_ns = 0; ref_er = 0; ref_clr = 0; ref_irq = 0;
            cyc = 0; hs_count = 0;
            expq.delete(); dnq.delete();
        end else begin
            cyc++;
            if (cyc == 1) begin
                chk(up_req_ready == 1'b1, "R8", "ready after reset", DW'(up_req_ready), 1);
                chk(dn_req_valid == 1'b0, "R8", "dn valid after reset", DW'(dn_req_valid), 0);
                chk(up_rsp_valid == 1'b0, "R8", "rsp valid after reset", DW'(up_rsp_valid), 0);
            end
            // R6/R7/R11: interrupt level against the cycle model
            chk(irq_o === ref_irq, ref_clr ? "R7" : "R6", "irq level", DW'(irq_o), DW'(ref_irq));

            if (up_rsp_valid) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R10", "unexpected response", 1, 0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    chk(up_rsp_rdata === e.data, tagname(e.tag), "response data", up_rsp_rdata, e.data);
                    chk(up_rsp_err === e.err, tagname(e.tag), "response error", DW'(up_rsp_err), DW'(e.err));
                    if (e.cyc >= 0)
                        chk(cyc == e.cyc, "R10", "local response cycle", DW'(cyc), DW'(e.cyc));
                end
            end

            if (dn_req_valid && dn_req_ready) begin
                if (dnq.size() == 0) begin
                    chk(1'b0, "R4", "downstream request for blocked access", DW'(dn_req_addr), 0);
                end else begin
                    dn_t d;
                    exp_t e;
                    d = dnq.pop_front();
                    chk(dn_req_addr === d.addr, "R9", "dn addr", DW'(dn_req_addr), DW'(d.addr));
                    chk(dn_req_write === d.wr, "R9", "dn write", DW'(dn_req_write), DW'(d.wr));
                    chk(dn_req_size === d.size, "R9", "dn size", DW'(dn_req_size), DW'(d.size));
                    chk(dn_req_wdata === d.wdata, "R9", "dn wdata", dn_req_wdata, d.wdata);
                    chk(dn_req_secure === d.sec, tagname(d.tag), "dn secure attr", DW'(dn_req_secure), DW'(d.sec));
                    e.cyc  = -1;
                    e.data = {d.addr, ~d.addr};
                    e.err  = d.addr[4];
                    e.tag  = 9;
                    expq.push_back(e);
                    hs_addr = d.addr;
                    hs_count++;
                end
            end

            begin
                bit set_irq;
                set_irq = 0;
                if (up_req_valid && up_req_ready) begin
                    int a;
                    int t;
                    a = model_act(up_req_addr, ref_ns, ref_er);
                    t = model_tag(up_req_addr, ref_ns, ref_er);
                    if (a < 2) begin
                        dn_t d;
                        d.addr = up_req_addr; d.wr = up_req_write; d.size = up_req_size;
                        d.wdata = up_req_wdata; d.sec = (a == 0); d.tag = t;
                        dnq.push_back(d);
                    end else begin
                        exp_t e;
                        e.cyc = cyc + 1; e.data = '0; e.err = (a == 3); e.tag = t;
                        expq.push_back(e);
                        if (a == 3 && !ref_clr) set_irq = 1;
                    end
                end
                ref_irq = ref_clr ? 1'b0 : (ref_irq | set_irq);
            end
            ref_ns  = cfg_nsec_master;
            ref_er  = cfg_err_on_block;
            ref_clr = irq_clr;
        end
    end

    // Downstream responder: ready pattern and delayed responses
    int   seen = 0;
    bit   pend = 0;
    int   pend_cnt = 0;
    logic [AW-1:0] pend_addr = '0;
    always @(posedge clk) begin
        #1;
        dn_rsp_valid = 1'b0;
        if (!rst_n) begin
            seen = 0; pend = 0;
        end else begin
            if (hs_count != seen) begin
                seen = hs_count; pend = 1;
                pend_addr = hs_addr; pend_cnt = int'(hs_addr[6:5]);
            end
            if (pend) begin
                if (pend_cnt == 0) begin
                    dn_rsp_valid = 1'b1;
                    dn_rsp_rdata = {pend_addr, ~pend_addr};
                    dn_rsp_err   = pend_addr[4];
                    pend = 0;
                end else begin
                    pend_cnt--;
                end
            end
        end
        dn_req_ready = (cyc % 3) != 1;
    end

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic access(input logic [AW-1:0] a, input logic wr, input logic [1:0] sz,
                          input logic [DW-1:0] wd, input bit wait_done);
        bit hs;
        up_req_valid = 1'b1; up_req_addr = a; up_req_write = wr;
        up_req_size = sz; up_req_wdata = wd;
        do begin
            @(negedge clk); hs = up_req_ready;
            @(posedge clk); #1;
        end while (!hs);
        up_req_valid = 1'b0;
        if (wait_done)
            while (expq.size() != 0 || dnq.size() != 0) begin @(posedge clk); #1; end
    endtask

    task automatic run();
        idle(3);
        rst_n = 1'b1;
        idle(3);
        // secure master: R3 secure region, R2 non-secure region, R1 exempt
        access(32'h0000_1000, 0, 2'd3, '0, 1);
        access(32'h8000_2040, 1, 2'd2, 64'h1122_3344_5566_7788, 1);
        access(32'hF000_0010, 0, 2'd1, '0, 1);
        access(32'h0000_0060, 1, 2'd0, 64'h0000_0000_0000_00A5, 1);
        // non-secure master, silent blocking (R4) and R11 timing
        cfg_nsec_master = 1'b1;
        access(32'hF000_0020, 0, 2'd2, '0, 1);
        access(32'h0000_3000, 0, 2'd3, '0, 1);
        access(32'h0000_3008, 1, 2'd3, 64'hDEAD_BEEF_0000_0001, 1);
        access(32'h8000_0010, 0, 2'd1, '0, 1);
        access(32'h0000_3010, 0, 2'd0, '0, 0);
        access(32'h0000_3018, 1, 2'd1, 64'h55, 1);
        // error blocking (R5) and interrupt (R6, R7)
        cfg_err_on_block = 1'b1;
        idle(1);
        access(32'h0000_4000, 0, 2'd2, '0, 1);
        idle(3);
        irq_clr = 1'b1;
        idle(2);
        access(32'h0000_4008, 1, 2'd2, 64'h77, 1);
        idle(1);
        irq_clr = 1'b0;
        idle(2);
        access(32'h0000_4010, 0, 2'd3, '0, 0);
        access(32'h0000_4018, 0, 2'd3, '0, 1);
        access(32'h8000_0100, 1, 2'd3, 64'h0123_4567_89AB_CDEF, 1);
        // clear and block in the same cycle: clear wins
        irq_clr = 1'b1;
        idle(1);
        access(32'h0000_4020, 0, 2'd0, '0, 1);
        irq_clr = 1'b0;
        idle(2);
        access(32'h0000_4028, 0, 2'd0, '0, 1);
        idle(2);
        // reset while the interrupt is set (R8)
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(3);
        access(32'h0000_5000, 0, 2'd2, '0, 1);
        access(32'hF000_0040, 1, 2'd1, 64'h9, 1);
        cfg_nsec_master = 1'b0;
        idle(1);
        access(32'hF000_0060, 0, 2'd3, '0, 1);
        idle(4);
    endtask

    initial begin
        fork
            run();
            begin
                repeat (20000) @(posedge clk);
                timeout = 1;
            end
        join_any
        if (timeout) $display("FAIL watchdog expired at cycle %0d actual=1 expected=0", cyc);
        $display("CHECKS %0d ERRORS %0d", checks + int'(timeout), errors + int'(timeout));
        $finish;
    end

endmodule